// File: doc/BRIEF.md
# Multi-Cycle Instruction Sequencing Controller

This block steps a multi-cycle 32-bit RISC datapath through each instruction. It reads the opcode held in the instruction register, the register-file function field, the destination register index and the ALU zero flag. From these it produces, one cycle at a time, the enables and selects that the datapath needs: program-counter update and source, instruction-register load, register-file write, immediate-extension mode, ALU operand source and operation, memory write, byte-or-word access and write-back source.

Every instruction starts in a fetch cycle and then a decode cycle. After that, each instruction class takes only the states it needs. Loads use execute, memory and write-back. Stores use execute and memory. ALU and immediate operations use execute and write-back. Branches end in execute. A no-operation, or any unknown opcode, goes straight back to fetch after decode. The datapath, the memories and the register file sit outside this block.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: `rst` is synchronous and active high. While it is high, `pc_we_o`, `ir_we_o`, `rf_we_o` and `mem_we_o` are all 0. After any clock edge at which it is high, `state_o` is 0 (fetch).
- R2: In fetch (`state_o`=0) the outputs are `pc_we_o`=1, `pc_sel_o`=0 (PC+4), `ir_we_o`=1, with every other control at 0. The following state is always decode (`state_o`=1).
- R3: The state codes are fetch=0, decode=1, execute=2, memory=3 and write-back=4. The opcodes (6 bits) are: ALU register op 0x20; addi 0x30, andi 0x32, ori 0x33, li 0x38 and lui 0x39; lb 0x03 and lw 0x0F; sb 0x07 and sw 0x1F; b 0x12, beq 0x10 and bne 0x11. The state paths are:
  - loads: 0,1,2,3,4
  - stores: 0,1,2,3
  - ALU and immediate operations: 0,1,2,4
  - branches: 0,1,2
  
  Every path then returns to 0.
- R4: Opcode 0x00 (NOP), and any opcode not listed in R3, takes the path 0,1 and then returns to fetch. In its decode cycle every control output is 0. Decode drives every control output to 0 for every opcode.
- R5: In execute, every branch drives `pc_sel_o`=1 (branch target). `pc_we_o` is then 1 under these conditions:
  - b: always
  - beq: only when `zero_i`=1
  - bne: only when `zero_i`=0
  
  `pc_we_o` is 0 in every state except fetch and the execute cycle of a taken branch.
- R6: `ext_mode_o` is 0 outside execute. In execute it is 0 (sign-extend) for addi, li, loads, stores and branches. It is 1 (zero-fill) for andi and ori, and 2 (shift left by 16) for lui.
- R7: In execute, `alu_src_imm_o` is 1 for immediate, load and store instructions. `alu_op_o` has these values:
  - ALU register op: equals `fn_i`
  - addi, li, lui, loads, stores and b: 0 (add)
  - beq and bne: 1 (subtract)
  - andi: 2 (and)
  - ori: 3 (or)
  
  Outside execute both outputs are 0.
- R8: `mem_we_o` is 1 only in the memory state of a store. `byte_sel_o` is 1 only in these cycles:
  - the memory state of lb or sb
  - the write-back state of lb
- R9: `rf_we_o` is 1 only in the write-back state. `wb_mem_o` is 1 only in the write-back state of a load.
- R10: When `dst_i` is 0, `rf_we_o` stays 0 in write-back, so register 0 is never written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 6 | Opcode from the instruction register |
| fn_i | input | 4 | ALU function field for register ops |
| dst_i | input | 5 | Destination register index |
| zero_i | input | 1 | ALU zero flag |
| state_o | output | 3 | Current sequencing state |
| pc_we_o | output | 1 | Program counter write enable |
| pc_sel_o | output | 1 | PC source: 0 = PC+4, 1 = branch target |
| ir_we_o | output | 1 | Instruction register load |
| rf_we_o | output | 1 | Register file write enable |
| ext_mode_o | output | 2 | Immediate extension mode |
| alu_src_imm_o | output | 1 | ALU second operand is the immediate |
| alu_op_o | output | 4 | ALU operation select |
| mem_we_o | output | 1 | Data memory write enable |
| byte_sel_o | output | 1 | Byte-wide memory access |
| wb_mem_o | output | 1 | Write-back takes memory data |

## Verification
The assertions take two things for granted about the inputs.

First, `op_i`, `fn_i` and `dst_i` come from an instruction register that holds steady from decode until the instruction's last state. The controller re-decodes the live opcode in every state, so a change of opcode in the middle of an instruction would send it down a different path.

Second, `zero_i` is stable during the execute cycle of a branch.

The stimulus changes these inputs only on a falling edge while the machine is in fetch. It keeps them fixed for the whole instruction. The one exception is the reset cases, which may arrive in the middle of an instruction.

// File: rtl/mcc_pkg.sv
package mcc_pkg;

    localparam int OP_W  = 6;
    localparam int FN_W  = 4;
    localparam int ST_W  = 3;

    typedef enum logic [ST_W-1:0] {
        ST_FETCH  = 3'd0,
        ST_DECODE = 3'd1,
        ST_EXEC   = 3'd2,
        ST_MEM    = 3'd3,
        ST_WB     = 3'd4
    } state_e;

    typedef enum logic [2:0] {
        CL_NOP, CL_ALU, CL_IMM, CL_LOAD, CL_STORE, CL_BRANCH
    } class_e;

    typedef enum logic [1:0] {
        EXT_SIGN = 2'd0,
        EXT_ZERO = 2'd1,
        EXT_HI16 = 2'd2
    } ext_e;

    typedef enum logic [1:0] {
        BR_NONE, BR_ALWAYS, BR_EQ, BR_NE
    } br_e;

    localparam logic [OP_W-1:0] OP_NOP  = 6'h00;
    localparam logic [OP_W-1:0] OP_ALU  = 6'h20;
    localparam logic [OP_W-1:0] OP_ADDI = 6'h30;
    localparam logic [OP_W-1:0] OP_ANDI = 6'h32;
    localparam logic [OP_W-1:0] OP_ORI  = 6'h33;
    localparam logic [OP_W-1:0] OP_LI   = 6'h38;
    localparam logic [OP_W-1:0] OP_LUI  = 6'h39;
    localparam logic [OP_W-1:0] OP_LB   = 6'h03;
    localparam logic [OP_W-1:0] OP_LW   = 6'h0F;
    localparam logic [OP_W-1:0] OP_SB   = 6'h07;
    localparam logic [OP_W-1:0] OP_SW   = 6'h1F;
    localparam logic [OP_W-1:0] OP_B    = 6'h12;
    localparam logic [OP_W-1:0] OP_BEQ  = 6'h10;
    localparam logic [OP_W-1:0] OP_BNE  = 6'h11;

    localparam logic [FN_W-1:0] ALU_ADD = 4'd0;
    localparam logic [FN_W-1:0] ALU_SUB = 4'd1;
    localparam logic [FN_W-1:0] ALU_AND = 4'd2;
    localparam logic [FN_W-1:0] ALU_OR  = 4'd3;

    typedef struct packed {
        class_e          cls;
        ext_e            ext;
        logic [FN_W-1:0] alu;
        logic            byte_op;
        br_e             br;
    } dec_t;

    typedef struct packed {
        logic            pc_we;
        logic            pc_sel;
        logic            ir_we;
        logic            rf_we;
        ext_e            ext;
        logic            src_imm;
        logic [FN_W-1:0] alu_op;
        logic            mem_we;
        logic            byte_sel;
        logic            wb_mem;
    } ctrl_t;

endpackage

// File: rtl/mcc_decode.sv
module mcc_decode
    import mcc_pkg::*;
(
    input  logic [OP_W-1:0] op_i,
    input  logic [FN_W-1:0] fn_i,
    output dec_t            dec_o
);

    always_comb begin
        dec_o         = '0;
        dec_o.cls     = CL_NOP;
        dec_o.ext     = EXT_SIGN;
        dec_o.alu     = ALU_ADD;
        dec_o.byte_op = 1'b0;
        dec_o.br      = BR_NONE;
        case (op_i)
            OP_ALU: begin
                dec_o.cls = CL_ALU;
                dec_o.alu = fn_i;
            end
            OP_ADDI, OP_LI: dec_o.cls = CL_IMM;
            OP_LUI: begin
                dec_o.cls = CL_IMM;
                dec_o.ext = EXT_HI16;
            end
            OP_ANDI: begin
                dec_o.cls = CL_IMM;
                dec_o.ext = EXT_ZERO;
                dec_o.alu = ALU_AND;
            end
            OP_ORI: begin
                dec_o.cls = CL_IMM;
                dec_o.ext = EXT_ZERO;
                dec_o.alu = ALU_OR;
            end
            OP_LB: begin
                dec_o.cls     = CL_LOAD;
                dec_o.byte_op = 1'b1;
            end
            OP_LW: dec_o.cls = CL_LOAD;
            OP_SB: begin
                dec_o.cls     = CL_STORE;
                dec_o.byte_op = 1'b1;
            end
            OP_SW: dec_o.cls = CL_STORE;
            OP_B: begin
                dec_o.cls = CL_BRANCH;
                dec_o.br  = BR_ALWAYS;
            end
            OP_BEQ: begin
                dec_o.cls = CL_BRANCH;
                dec_o.br  = BR_EQ;
                dec_o.alu = ALU_SUB;
            end
            OP_BNE: begin
                dec_o.cls = CL_BRANCH;
                dec_o.br  = BR_NE;
                dec_o.alu = ALU_SUB;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/mcc_outputs.sv
module mcc_outputs
    import mcc_pkg::*;
(
    input  state_e state_i,
    input  dec_t   dec_i,
    input  logic   zero_i,
    input  logic   dst_ok_i,
    input  logic   quiet_i,
    output ctrl_t  ctrl_o
);

    logic taken;

    always_comb begin
        unique case (dec_i.br)
            BR_ALWAYS: taken = 1'b1;
            BR_EQ:     taken = zero_i;
            BR_NE:     taken = ~zero_i;
            default:   taken = 1'b0;
        endcase
    end

    always_comb begin
        ctrl_o     = '0;
        ctrl_o.ext = EXT_SIGN;
        case (state_i)
            ST_FETCH: begin
                ctrl_o.pc_we = 1'b1;
                ctrl_o.ir_we = 1'b1;
            end
            ST_EXEC: begin
                if (dec_i.cls != CL_NOP) begin
                    ctrl_o.ext     = dec_i.ext;
                    ctrl_o.alu_op  = dec_i.alu;
                    ctrl_o.src_imm = (dec_i.cls == CL_IMM) || (dec_i.cls == CL_LOAD)
                                   || (dec_i.cls == CL_STORE);
                end
                if (dec_i.cls == CL_BRANCH) begin
                    ctrl_o.pc_sel = 1'b1;
                    ctrl_o.pc_we  = taken;
                end
            end
            ST_MEM: begin
                ctrl_o.mem_we   = (dec_i.cls == CL_STORE);
                ctrl_o.byte_sel = dec_i.byte_op;
            end
            ST_WB: begin
                ctrl_o.rf_we    = dst_ok_i;
                ctrl_o.wb_mem   = (dec_i.cls == CL_LOAD);
                ctrl_o.byte_sel = dec_i.byte_op && (dec_i.cls == CL_LOAD);
            end
            default: ;
        endcase
        if (quiet_i) begin
            ctrl_o     = '0;
            ctrl_o.ext = EXT_SIGN;
        end
    end

endmodule

// File: rtl/mc_ctrl_fsm.sv
module mc_ctrl_fsm
    import mcc_pkg::*;
#(
    parameter int DST_W    = 5,
    parameter bit R0_GUARD = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [OP_W-1:0]  op_i,
    input  logic [FN_W-1:0]  fn_i,
    input  logic [DST_W-1:0] dst_i,
    input  logic             zero_i,
    output logic [ST_W-1:0]  state_o,
    output logic             pc_we_o,
    output logic             pc_sel_o,
    output logic             ir_we_o,
    output logic             rf_we_o,
    output logic [1:0]       ext_mode_o,
    output logic             alu_src_imm_o,
    output logic [FN_W-1:0]  alu_op_o,
    output logic             mem_we_o,
    output logic             byte_sel_o,
    output logic             wb_mem_o
);

    typedef struct packed {
        state_e state;
    } regs_t;

    regs_t regs_d, regs_q;
    dec_t  dec;
    ctrl_t ctrl;
    logic  dst_ok;

    mcc_decode u_decode (
        .op_i  (op_i),
        .fn_i  (fn_i),
        .dec_o (dec)
    );

    generate
        if (R0_GUARD) begin : g_r0_guard
            assign dst_ok = |dst_i;
        end else begin : g_no_guard
            assign dst_ok = 1'b1;
        end
    endgenerate

    always_comb begin
        regs_d = regs_q;
        case (regs_q.state)
            ST_FETCH:  regs_d.state = ST_DECODE;
            ST_DECODE: regs_d.state = (dec.cls == CL_NOP) ? ST_FETCH : ST_EXEC;
            ST_EXEC: begin
                case (dec.cls)
                    CL_LOAD, CL_STORE: regs_d.state = ST_MEM;
                    CL_ALU, CL_IMM:    regs_d.state = ST_WB;
                    default:           regs_d.state = ST_FETCH;
                endcase
            end
            ST_MEM:    regs_d.state = (dec.cls == CL_LOAD) ? ST_WB : ST_FETCH;
            default:   regs_d.state = ST_FETCH;
        endcase
        if (rst) begin
            regs_d.state = ST_FETCH;
        end
    end

    always_ff @(posedge clk) begin
        regs_q <= regs_d;
    end

    mcc_outputs u_outputs (
        .state_i  (regs_q.state),
        .dec_i    (dec),
        .zero_i   (zero_i),
        .dst_ok_i (dst_ok),
        .quiet_i  (rst),
        .ctrl_o   (ctrl)
    );

    assign state_o       = regs_q.state;
    assign pc_we_o       = ctrl.pc_we;
    assign pc_sel_o      = ctrl.pc_sel;
    assign ir_we_o       = ctrl.ir_we;
    assign rf_we_o       = ctrl.rf_we;
    assign ext_mode_o    = ctrl.ext;
    assign alu_src_imm_o = ctrl.src_imm;
    assign alu_op_o      = ctrl.alu_op;
    assign mem_we_o      = ctrl.mem_we;
    assign byte_sel_o    = ctrl.byte_sel;
    assign wb_mem_o      = ctrl.wb_mem;

endmodule

// File: rtl/mc_ctrl_fsm_chk.sv
module mc_ctrl_fsm_chk #(
    parameter int DST_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic [DST_W-1:0] dst_i,
    input logic [2:0]       state_o,
    input logic             pc_we_o,
    input logic             pc_sel_o,
    input logic             ir_we_o,
    input logic             rf_we_o,
    input logic [1:0]       ext_mode_o,
    input logic             mem_we_o,
    input logic             wb_mem_o
);

    // R1
    reset_state_chk: assert property (@(posedge clk) rst |=> state_o == 3'd0);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |-> !(pc_we_o || ir_we_o || rf_we_o || mem_we_o));

    // R2
    fetch_next_chk: assert property (@(posedge clk) disable iff (rst)
        state_o == 3'd0 |=> state_o == 3'd1);

    // R2
    ir_load_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        ir_we_o |-> state_o == 3'd0);

    // R3
    wb_return_chk: assert property (@(posedge clk) disable iff (rst)
        state_o == 3'd4 |=> state_o == 3'd0);

    // R5
    branch_target_chk: assert property (@(posedge clk) disable iff (rst)
        (pc_we_o && state_o == 3'd2) |-> pc_sel_o);

    // R6
    ext_legal_chk: assert property (@(posedge clk) disable iff (rst)
        ext_mode_o != 2'd3 && (state_o != 3'd2 -> ext_mode_o == 2'd0));

    // R8
    mem_write_state_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we_o |-> state_o == 3'd3);

    // R9
    rf_write_state_chk: assert property (@(posedge clk) disable iff (rst)
        (rf_we_o || wb_mem_o) |-> state_o == 3'd4);

    // R10
    r0_protect_chk: assert property (@(posedge clk) disable iff (rst)
        rf_we_o |-> dst_i != '0);

    // R8
    single_write_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ir_we_o, rf_we_o, mem_we_o}));

endmodule

bind mc_ctrl_fsm mc_ctrl_fsm_chk #(.DST_W(DST_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .dst_i      (dst_i),
    .state_o    (state_o),
    .pc_we_o    (pc_we_o),
    .pc_sel_o   (pc_sel_o),
    .ir_we_o    (ir_we_o),
    .rf_we_o    (rf_we_o),
    .ext_mode_o (ext_mode_o),
    .mem_we_o   (mem_we_o),
    .wb_mem_o   (wb_mem_o)
);

// File: tb/mc_ctrl_fsm_test.sv
module mc_ctrl_fsm_test;

    localparam logic [5:0] K_NOP = 6'h00, K_ALU = 6'h20, K_ADDI = 6'h30, K_ANDI = 6'h32;
    localparam logic [5:0] K_ORI = 6'h33, K_LI = 6'h38, K_LUI = 6'h39, K_LB = 6'h03;
    localparam logic [5:0] K_LW = 6'h0F, K_SB = 6'h07, K_SW = 6'h1F, K_B = 6'h12;
    localparam logic [5:0] K_BEQ = 6'h10, K_BNE = 6'h11, K_BAD = 6'h2A;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] op = '0;
    logic [3:0] fn = '0;
    logic [4:0] dst = '0;
    logic       zero = 1'b0;
    logic [2:0] state;
    logic       pc_we, pc_sel, ir_we, rf_we, src_imm, mem_we, byte_sel, wb_mem;
    logic [1:0] ext;
    logic [3:0] alu_op;
    int         checks = 0;
    int         failures = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    mc_ctrl_fsm uut (
        .clk(clk), .rst(rst), .op_i(op), .fn_i(fn), .dst_i(dst), .zero_i(zero),
        .state_o(state), .pc_we_o(pc_we), .pc_sel_o(pc_sel), .ir_we_o(ir_we),
        .rf_we_o(rf_we), .ext_mode_o(ext), .alu_src_imm_o(src_imm), .alu_op_o(alu_op),
        .mem_we_o(mem_we), .byte_sel_o(byte_sel), .wb_mem_o(wb_mem)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic bit is_load(logic [5:0] o);  return o == K_LB || o == K_LW; endfunction
    function automatic bit is_store(logic [5:0] o); return o == K_SB || o == K_SW; endfunction
    function automatic bit is_br(logic [5:0] o);    return o == K_B || o == K_BEQ || o == K_BNE; endfunction
    function automatic bit is_imm(logic [5:0] o);
        return o == K_ADDI || o == K_ANDI || o == K_ORI || o == K_LI || o == K_LUI;
    endfunction

    // Reference path of states for one instruction
    function automatic void path_of(input logic [5:0] o, ref int q[$]);
        q = {0, 1};
        if (is_load(o))                      q = {0, 1, 2, 3, 4};
        else if (is_store(o))                q = {0, 1, 2, 3};
        else if (is_imm(o) || o == K_ALU)    q = {0, 1, 2, 4};
        else if (is_br(o))                   q = {0, 1, 2};
    endfunction

    task automatic compare(input int st);
        int  e_pcw = 0, e_pcs = 0, e_irw = 0, e_rfw = 0, e_ext = 0, e_src = 0;
        int  e_alu = 0, e_mw = 0, e_bs = 0, e_wbm = 0;
        bit  known = is_load(op) || is_store(op) || is_br(op) || is_imm(op) || op == K_ALU;
        string pc_tag = (st == 0) ? "R2" : "R5";
        string rf_tag = (dst == 0) ? "R10" : "R9";
        if (st == 0) begin e_pcw = 1; e_irw = 1; end
        if (st == 2 && known) begin
            if (op == K_LUI) e_ext = 2;
            if (op == K_ANDI || op == K_ORI) e_ext = 1;
            e_src = (is_imm(op) || is_load(op) || is_store(op)) ? 1 : 0;
            if (op == K_ALU) e_alu = fn;
            if (op == K_BEQ || op == K_BNE) e_alu = 1;
            if (op == K_ANDI) e_alu = 2;
            if (op == K_ORI) e_alu = 3;
            if (is_br(op)) begin
                e_pcs = 1;
                e_pcw = (op == K_B) || (op == K_BEQ && zero) || (op == K_BNE && !zero);
            end
        end
        if (st == 3) begin
            e_mw = is_store(op);
            e_bs = (op == K_LB || op == K_SB);
        end
        if (st == 4) begin
            e_rfw = (dst != 0);
            e_wbm = is_load(op);
            e_bs  = (op == K_LB);
        end
        if (st == 1)
            chk("R4", "decode quiet", int'({pc_we, pc_sel, ir_we, rf_we, ext, src_imm,
                alu_op, mem_we, byte_sel, wb_mem}), 0);
        chk(pc_tag, "pc_we", pc_we, e_pcw);
        chk(pc_tag, "pc_sel", pc_sel, e_pcs);
        chk("R2", "ir_we", ir_we, e_irw);
        chk(rf_tag, "rf_we", rf_we, e_rfw);
        chk("R6", "ext_mode", ext, e_ext);
        chk("R7", "alu_src_imm", src_imm, e_src);
        chk("R7", "alu_op", alu_op, e_alu);
        chk("R8", "mem_we", mem_we, e_mw);
        chk("R8", "byte_sel", byte_sel, e_bs);
        chk("R9", "wb_mem", wb_mem, e_wbm);
    endtask

    // Called at a falling edge while the machine is in fetch
    task automatic run(input logic [5:0] o, input logic [3:0] f, input logic [4:0] d, input logic z);
        int q[$];
        bit known = is_load(o) || is_store(o) || is_br(o) || is_imm(o) || o == K_ALU;
        op = o; fn = f; dst = d; zero = z;
        path_of(o, q);
        foreach (q[i]) begin
            #0;
            chk(known ? "R3" : "R4", $sformatf("state op=%0h step %0d", o, i), state, q[i]);
            compare(q[i]);
            @(negedge clk);
        end
        chk(known ? "R3" : "R4", $sformatf("return to fetch op=%0h", o), state, 0);
    endtask

    task automatic check_reset_quiet();
        chk("R1", "state in reset", state, 0);
        chk("R1", "enables in reset", int'({pc_we, ir_we, rf_we, mem_we}), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R3 watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        chk("R1", "enables before first edge", int'({pc_we, ir_we, rf_we, mem_we}), 0);
        repeat (2) begin @(negedge clk); check_reset_quiet(); end
        rst = 1'b0;
        #0;
        compare(0);

        run(K_NOP, 4'd0, 5'd3, 1'b0);
        run(K_BAD, 4'd0, 5'd3, 1'b0);
        run(K_ALU, 4'd5, 5'd7, 1'b0);
        run(K_ALU, 4'd9, 5'd31, 1'b1);
        run(K_ALU, 4'd1, 5'd0, 1'b0);
        run(K_ADDI, 4'd0, 5'd2, 1'b0);
        run(K_LI, 4'd0, 5'd2, 1'b0);
        run(K_LUI, 4'd0, 5'd4, 1'b0);
        run(K_ANDI, 4'd0, 5'd6, 1'b0);
        run(K_ORI, 4'd0, 5'd8, 1'b0);
        run(K_LW, 4'd0, 5'd9, 1'b0);
        run(K_LB, 4'd0, 5'd10, 1'b0);
        run(K_LW, 4'd0, 5'd0, 1'b0);
        run(K_SW, 4'd0, 5'd11, 1'b0);
        run(K_SB, 4'd0, 5'd12, 1'b0);
        run(K_BEQ, 4'd0, 5'd0, 1'b1);
        run(K_BEQ, 4'd0, 5'd0, 1'b0);
        run(K_BNE, 4'd0, 5'd0, 1'b1);
        run(K_BNE, 4'd0, 5'd0, 1'b0);
        run(K_B, 4'd0, 5'd0, 1'b0);
        run(K_B, 4'd0, 5'd0, 1'b1);

        // Reset in the middle of a load: after fetch, decode, execute
        op = K_LW; dst = 5'd5;
        repeat (3) @(negedge clk);
        chk("R1", "mid-run state before reset", state, 3);
        rst = 1'b1;
        #0;
        chk("R1", "enables during mid-run reset", int'({pc_we, ir_we, rf_we, mem_we}), 0);
        @(negedge clk);
        check_reset_quiet();
        rst = 1'b0;
        run(K_SW, 4'd0, 5'd1, 1'b0);
        run(K_ALU, 4'd2, 5'd1, 1'b0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule